// File: doc/BRIEF.md
# Three-wire codec control serializer

This block writes single bytes into the control port of an audio codec over a three-wire serial link. The link has a mode wire, a data wire and a clock wire. A host offers a byte and a mode flag together with a one-cycle start strobe. The block then does four things in order:

- It drives the mode wire to the requested value.
- It holds the clock high for a minimum setup time.
- It sends the eight bits least significant first. Each bit is placed on the data wire as the clock falls and is held while the clock rises, so the codec samples on the rising edge.
- It parks the link with mode high, clock high and data low, and pulses `done_o` for one cycle.

A mode value of 0 marks an address byte and a mode value of 1 marks a data byte. The setup time is counted in system clocks and rounded up, so the default 190 ns at a 10 ns clock becomes 19 cycles. The length of each clock half-period is set by the divider parameter `HALF_CYC`.

The controller is a four-state machine:

- `ST_IDLE` (link parked) goes to `ST_SETUP` when start is seen.
- `ST_SETUP` (mode set, clock high) goes to `ST_LOW` when the setup count expires.
- `ST_LOW` (clock low, bit presented) goes to `ST_HIGH` when the half-period expires.
- `ST_HIGH` (clock high, bit held) goes to `ST_LOW` when the half-period expires and bits remain. After the eighth bit it goes to `ST_IDLE` and raises the done pulse.

Top module: `codec_ctl_ser`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the outputs are ctl_clk_o=1, ctl_mode_o=1, ctl_dat_o=0, busy_o=0 and done_o=0. A reset in the middle of a transfer returns the outputs to this state at once.
- R2: A start_i sampled while busy_o=0 gives, in the next cycle, busy_o=1, ctl_clk_o=1, ctl_dat_o=0 and ctl_mode_o equal to mode_i (0 = address, 1 = data). ctl_mode_o keeps that value until busy_o falls.
- R3: ctl_clk_o stays high for exactly SETUP_CYC = ceil(SETUP_PS / CLK_PERIOD_PS) cycles, counted from the first busy cycle, before its first falling edge. The default is 19 cycles.
- R4: Eight bits go out, byte_i bit 0 first. ctl_dat_o changes only where ctl_clk_o falls, and it holds its value across the following rising edge.
- R5: Every low and every high clock half-period during the bit phase lasts exactly HALF_CYC cycles.
- R6: After the eighth high half-period, busy_o=0 and the link is parked (clock 1, mode 1, data 0). busy_o stays high for SETUP_CYC + 16*HALF_CYC cycles in total.
- R7: done_o is high for exactly one cycle, which is the first cycle after busy_o falls.
- R8: A start_i raised while busy_o=1 is ignored. The transfer in progress keeps its byte, mode and timing, and no further transfer follows it.
- R9: A start_i given in the done_o cycle is accepted, so transfers can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; ignored while busy |
| mode_i | input | 1 | Mode for this transfer: 0 address, 1 data |
| byte_i | input | 8 | Byte to send, captured at start |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when a transfer ends |
| ctl_mode_o | output | 1 | Link mode wire |
| ctl_dat_o | output | 1 | Link data wire |
| ctl_clk_o | output | 1 | Link clock wire |

## Verification
Two functions can land in the same cycle: the end-of-transfer done pulse and the acceptance of a new start. The bench provokes this by raising start exactly in the done cycle. It judges the result by checking that the next cycle shows busy with the new mode on the link, and that the second transfer's bits and timing are complete. The bench also holds start high with an inverted byte and mode for the whole of a transfer. It judges this case by the bits sampled at each rising clock edge, the half-period lengths, and busy staying low once the done pulse has passed.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
    localparam int unsigned XFER_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH
    } ccs_state_e;
endpackage

// File: rtl/ccs_timer.sv
module ccs_timer #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Loading a length of N makes zero_o appear after N cycles in the state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ccs_shifter.sv
module ccs_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    input  logic         adv_i,
    output logic         bit_o,
    output logic         last_o
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  sr_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            sr_q  <= din_i;
            cnt_q <= '0;
        end else if (adv_i) begin
            sr_q  <= sr_q >> 1;
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign bit_o  = sr_q[0];
    assign last_o = (cnt_q == CW'(W));
endmodule

// File: rtl/codec_ctl_ser.sv
module codec_ctl_ser
    import ccs_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned SETUP_PS      = 190000,
    parameter int unsigned HALF_CYC      = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 mode_i,
    input  logic [XFER_BITS-1:0] byte_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 ctl_mode_o,
    output logic                 ctl_dat_o,
    output logic                 ctl_clk_o
);
    localparam int unsigned SETUP_RAW = (SETUP_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int unsigned SETUP_LD  = (SETUP_RAW == 0) ? 1 : SETUP_RAW;
    localparam int unsigned HALF_LD   = (HALF_CYC == 0) ? 1 : HALF_CYC;
    localparam int unsigned TMR_MAX   = (SETUP_LD > HALF_LD) ? SETUP_LD : HALF_LD;
    localparam int unsigned TMR_W     = $clog2(TMR_MAX + 1);

    ccs_state_e       state_q, state_d;
    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_len;
    logic             sh_load, sh_adv, sh_bit, sh_last;

    ccs_timer #(.W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .zero_o (tmr_zero)
    );

    ccs_shifter #(.W(XFER_BITS)) u_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sh_load),
        .din_i  (byte_i),
        .adv_i  (sh_adv),
        .bit_o  (sh_bit),
        .last_o (sh_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and datapath controls
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_len  = TMR_W'(HALF_LD);
        sh_load  = 1'b0;
        sh_adv   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_len  = TMR_W'(SETUP_LD);
                    sh_load  = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    state_d  = ST_LOW;
                    tmr_load = 1'b1;
                end
            end
            ST_LOW: begin
                if (tmr_zero) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                    sh_adv   = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    if (sh_last) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d  = ST_LOW;
                        tmr_load = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_clk_o  <= 1'b1;
            ctl_mode_o <= 1'b1;
            ctl_dat_o  <= 1'b0;
            busy_o     <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            busy_o <= (state_d != ST_IDLE);
            done_o <= (state_q == ST_HIGH) && (state_d == ST_IDLE);
            unique case (state_d)
                ST_IDLE: begin
                    ctl_clk_o  <= 1'b1;
                    ctl_mode_o <= 1'b1;
                    ctl_dat_o  <= 1'b0;
                end
                ST_SETUP: begin
                    ctl_clk_o <= 1'b1;
                    ctl_dat_o <= 1'b0;
                    if (state_q == ST_IDLE) begin
                        ctl_mode_o <= mode_i;
                    end
                end
                ST_LOW: begin
                    ctl_clk_o <= 1'b0;
                    if (state_q != ST_LOW) begin
                        ctl_dat_o <= sh_bit;
                    end
                end
                ST_HIGH: begin
                    ctl_clk_o <= 1'b1;
                end
                default: begin
                    ctl_clk_o <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/ccs_chk.sv
module ccs_chk #(
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned SETUP_PS      = 190000,
    parameter int unsigned HALF_CYC      = 3
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic ctl_mode_o,
    input logic ctl_dat_o,
    input logic ctl_clk_o
);
    localparam int unsigned SETUP_RAW = (SETUP_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int unsigned SETUP_MIN = (SETUP_RAW == 0) ? 1 : SETUP_RAW;

    logic [31:0] run_q;
    logic        lvl_q;
    logic        first_q;

    // Length of the current clock level inside a transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            lvl_q   <= 1'b1;
            first_q <= 1'b1;
        end else begin
            lvl_q <= ctl_clk_o;
            if (!busy_o) begin
                run_q <= '0;
            end else if (ctl_clk_o != lvl_q) begin
                run_q <= 32'd1;
            end else begin
                run_q <= run_q + 32'd1;
            end
            if (!busy_o) begin
                first_q <= 1'b1;
            end else if (!ctl_clk_o) begin
                first_q <= 1'b0;
            end
        end
    end

    AST_IDLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ctl_clk_o && ctl_mode_o && !ctl_dat_o));                 // R6
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(ctl_mode_o));                   // R2
    AST_SETUP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $fell(ctl_clk_o) && first_q) |-> (run_q >= SETUP_MIN));    // R3
    AST_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $rose(ctl_clk_o)) |-> (run_q == HALF_CYC));                // R5
    AST_HIGH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $fell(ctl_clk_o) && !first_q) |-> (run_q == HALF_CYC));    // R5
    AST_DAT_HOLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_clk_o) |-> $stable(ctl_dat_o));                             // R4
    AST_DAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !$fell(ctl_clk_o)) |-> $stable(ctl_dat_o)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                  // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));                               // R7
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);                                     // R9
endmodule

bind codec_ctl_ser ccs_chk #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .SETUP_PS      (SETUP_PS),
    .HALF_CYC      (HALF_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ctl_mode_o (ctl_mode_o),
    .ctl_dat_o  (ctl_dat_o),
    .ctl_clk_o  (ctl_clk_o)
);

// File: tb/codec_ctl_ser_bench.sv
module codec_ctl_ser_bench;
    localparam int unsigned PERIOD_PS = 10000;
    localparam int unsigned SET_PS    = 190000;
    localparam int unsigned HALF      = 3;
    localparam int          E_SETUP   = 19;
    localparam int          E_BUSY    = E_SETUP + 16 * HALF;
    localparam int          VN        = 7;
    // {mode, byte}
    localparam logic [8:0] VEC [VN] = '{
        {1'b0, 8'h00}, {1'b1, 8'hFF}, {1'b0, 8'hA5}, {1'b1, 8'h5A},
        {1'b0, 8'h01}, {1'b1, 8'h80}, {1'b1, 8'h3C}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic       mode_i;
    logic [7:0] byte_i;
    logic       busy_o, done_o, ctl_mode_o, ctl_dat_o, ctl_clk_o;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    codec_ctl_ser #(
        .CLK_PERIOD_PS (PERIOD_PS),
        .SETUP_PS      (SET_PS),
        .HALF_CYC      (HALF)
    ) u_codec_ctl_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .byte_i     (byte_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .ctl_mode_o (ctl_mode_o),
        .ctl_dat_o  (ctl_dat_o),
        .ctl_clk_o  (ctl_clk_o)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic park_chk(input string rq);
        chk(ctl_clk_o === 1'b1 && ctl_mode_o === 1'b1 && ctl_dat_o === 1'b0 && busy_o === 1'b0,
            rq, {ctl_clk_o, ctl_mode_o, ctl_dat_o, busy_o}, 4'b1100);
    endtask

    // Called at a falling clock edge; returns at the done sample.
    task automatic xfer(input logic m, input logic [7:0] b, input bit hammer, output bit ok);
        int cyc, run, nb, nfall, setup_len, bad_half, bad_dat, bad_mode;
        logic prv, pdat;
        logic [7:0] got;
        int err0;
        err0 = errors;
        start_i = 1'b1; mode_i = m; byte_i = b;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1 && ctl_clk_o === 1'b1 && ctl_dat_o === 1'b0 && ctl_mode_o === m,
            "R2 accept", {ctl_mode_o, ctl_clk_o, ctl_dat_o, busy_o}, {m, 3'b101});
        cyc = 1; run = 1; prv = 1'b1; pdat = 1'b0; nb = 0; nfall = 0;
        setup_len = 0; bad_half = 0; bad_dat = 0; bad_mode = 0; got = '0;
        forever begin
            if (hammer) begin start_i = 1'b1; mode_i = ~m; byte_i = ~b; end
            @(negedge clk);
            if (!busy_o) break;
            cyc++;
            if (ctl_mode_o !== m) bad_mode++;
            if (ctl_clk_o !== prv) begin
                if (prv === 1'b1) begin
                    if (nfall == 0) setup_len = run;
                    else if (run != HALF) bad_half++;
                    nfall++;
                end else begin
                    if (run != HALF) bad_half++;
                    if (ctl_dat_o !== pdat) bad_dat++;
                    if (nb < 8) got[nb] = ctl_dat_o;
                    nb++;
                end
                run = 1;
            end else begin
                run++;
                if (ctl_dat_o !== pdat) bad_dat++;
            end
            prv = ctl_clk_o; pdat = ctl_dat_o;
        end
        start_i = 1'b0;
        chk(bad_mode == 0, "R2 mode held", bad_mode, 0);
        chk(setup_len == E_SETUP, "R3 setup length", setup_len, E_SETUP);
        chk(got == b && nb == 8, "R4 bits lsb first", {nb[7:0], got}, {8'd8, b});
        chk(bad_dat == 0, "R4 data only at fall", bad_dat, 0);
        chk(bad_half == 0 && run == HALF, "R5 half periods", {bad_half[15:0], run[15:0]}, {16'd0, 16'(HALF)});
        chk(cyc == E_BUSY, "R6 busy length", cyc, E_BUSY);
        park_chk("R6 park");
        chk(done_o === 1'b1, "R7 done at end", done_o, 1);
        ok = (errors == err0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit ok;
        rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; byte_i = '0;
        repeat (3) @(negedge clk);
        park_chk("R1 in reset");
        chk(done_o === 1'b0, "R1 no done in reset", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        park_chk("R1 after release");
        chk(done_o === 1'b0, "R1 no done after release", done_o, 0);

        // Vector walk
        for (int i = 0; i < VN; i++) begin
            @(negedge clk);
            xfer(VEC[i][8], VEC[i][7:0], 1'b0, ok);
            @(negedge clk);
            chk(done_o === 1'b0 && busy_o === 1'b0, "R7 done one cycle", {done_o, busy_o}, 0);
        end

        // R8: start hammered during a transfer
        @(negedge clk);
        xfer(1'b0, 8'h96, 1'b1, ok);
        chk(ok, "R8 busy start ignored", ok, 1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(busy_o === 1'b0 && done_o === 1'b0, "R8 no extra transfer", {busy_o, done_o}, 0);
        end

        // R9: start in the done cycle
        @(negedge clk);
        xfer(1'b1, 8'hC3, 1'b0, ok);
        xfer(1'b0, 8'h6E, 1'b0, ok);
        chk(ok, "R9 back-to-back transfer", ok, 1);
        @(negedge clk);
        chk(done_o === 1'b0, "R9 done cleared", done_o, 0);

        // R1: reset in the middle of a transfer
        start_i = 1'b1; mode_i = 1'b0; byte_i = 8'h55;
        @(negedge clk);
        start_i = 1'b0;
        repeat (25) @(negedge clk);
        rst_n = 1'b0;
        #1;
        park_chk("R1 mid-transfer reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        park_chk("R1 idle after reset");
        xfer(1'b1, 8'h9B, 1'b0, ok);
        chk(ok, "R1 recovery transfer", ok, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule